// File: doc/BRIEF.md
# I2C Digital Potentiometer Controller

This block is the digital side of a 256-step potentiometer. It is an I2C slave that holds one 8-bit wiper code. A host can write the code, reset it to the middle position, put the output into a zero-power shutdown, and read the code back. The slave address has six fixed upper bits. Its lowest bit comes from a strap pin, so two instances can share one bus.

SCL and SDA reach the block as plain inputs. Each passes through a two-flop synchroniser clocked by the system clock, which must run at least eight times faster than SCL. The block pulls SDA low through an open-drain enable. A write transaction carries the address, then a command byte holding the midscale and shutdown flags, then any number of code bytes. A read transaction returns the code once for every byte the master acknowledges.

The analog stage takes the effective tap code from the block. That code is the stored wiper value in normal operation and 0x00 in shutdown. Shutdown never alters the stored value.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset the stored wiper code is 0x80, shutdown is off, the tap code is 0x80 and SDA is released.
- R2: The block acknowledges an address byte of 0,1,0,1,1,0,strap sent MSB first, followed by a direction bit (1 = read, 0 = write), by pulling SDA low during the ninth SCL clock.
- R3: On an address mismatch the block gives no acknowledge and ignores every later byte until the next START. Neither the wiper code nor the shutdown state changes.
- R4: In the command byte, bit 6 set loads the wiper code with 0x80 when the byte is acknowledged, replacing the old value.
- R5: In the command byte, bit 5 sets shutdown when it is 1 and clears it when it is 0. Bit 7 and bits 4..0 are ignored. Entering shutdown leaves the stored code unchanged.
- R6: Every byte after the command byte in a write transaction is acknowledged and replaces the wiper code.
- R7: While shutdown is on the tap code is 0x00, and code bytes still update the stored value. When shutdown is cleared the tap code equals the stored value.
- R8: After a read address is acknowledged, the block drives the wiper code MSB first. A master ACK on the ninth clock repeats the byte. A master NACK ends the read with SDA released.
- R9: The block changes its SDA drive only while SCL is low.
- R10: A START or STOP in the middle of a byte aborts the transaction with no update. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| strap_i | input | 1 | Level of the address strap pin, used as address bit 0 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_o | output | 8 | Stored wiper code |
| shdn_o | output | 1 | Shutdown active |
| tap_o | output | 8 | Effective tap code for the resistor ladder |

## Verification
The assertions check on every cycle the properties that hold at any moment. SDA drive is asserted and the wiper code changes only while SCL is low. The tap code stays frozen throughout shutdown and matches the stored code once shutdown ends. Entering shutdown does not disturb the stored code. SDA is never driven right after a START. Only the bench scenarios can show the protocol itself: address matching with both strap levels, the ordering of command and code bytes, multi-byte writes, repeated reads under master ACK and NACK, and aborts on a START or STOP in the middle of a byte.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    // Bytes on the bus are always eight bits wide.
    localparam int BYTE_W = 8;

    // Bit positions decoded from the command byte.
    localparam int CMD_MID_BIT  = 6;
    localparam int CMD_SHDN_BIT = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BIT,
        ST_RD_ACK
    } bus_st_e;

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_s;
    logic  sda_s;

    assign scl_s = sync_q.scl_ff[STAGES-1];
    assign sda_s = sync_q.sda_ff[STAGES-1];

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_ff   = {sync_q.scl_ff[STAGES-2:0], scl_i};
        sync_d.sda_ff   = {sync_q.sda_ff[STAGES-2:0], sda_i};
        sync_d.scl_prev = scl_s;
        sync_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~sync_q.scl_prev;
    assign scl_fall_o = ~scl_s & sync_q.scl_prev;
    assign start_o    = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_o     = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/dpot_bus_fsm.sv
module dpot_bus_fsm
    import dpot_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b010110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              strap_i,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_vld,
    output logic              data_vld,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int             CW       = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0]  CNT_FULL = CW'(BYTE_W);
    localparam logic [CW-1:0]  CNT_LAST = CW'(BYTE_W - 1);
    localparam logic [CW-1:0]  CNT_ONE  = CW'(1);

    typedef struct packed {
        bus_st_e           st;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] sh;
        logic              oe;
        logic              rd;
        logic              mack;
        logic              cvld;
        logic              dvld;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.cvld = 1'b0;
        fsm_d.dvld = 1'b0;

        if (stop_evt) begin
            fsm_d.st  = ST_IDLE;
            fsm_d.oe  = 1'b0;
            fsm_d.cnt = '0;
        end else if (start_evt) begin
            fsm_d.st  = ST_ADDR;
            fsm_d.oe  = 1'b0;
            fsm_d.cnt = '0;
        end else begin
            unique case (fsm_q.st)
                ST_ADDR, ST_CMD, ST_DATA: begin
                    if (scl_rise && (fsm_q.cnt < CNT_FULL)) begin
                        fsm_d.sh  = {fsm_q.sh[BYTE_W-2:0], sda_s};
                        fsm_d.cnt = fsm_q.cnt + CNT_ONE;
                    end else if (scl_fall && (fsm_q.cnt == CNT_FULL)) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.st == ST_ADDR) begin
                            if (fsm_q.sh[BYTE_W-1:1] == {ADDR_HI, strap_i}) begin
                                fsm_d.oe = 1'b1;
                                fsm_d.rd = fsm_q.sh[0];
                                fsm_d.st = ST_ADDR_ACK;
                            end else begin
                                fsm_d.st = ST_IDLE;
                            end
                        end else if (fsm_q.st == ST_CMD) begin
                            fsm_d.oe   = 1'b1;
                            fsm_d.cvld = 1'b1;
                            fsm_d.st   = ST_CMD_ACK;
                        end else begin
                            fsm_d.oe   = 1'b1;
                            fsm_d.dvld = 1'b1;
                            fsm_d.st   = ST_DATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.rd) begin
                            fsm_d.sh = rd_data;
                            fsm_d.oe = ~rd_data[BYTE_W-1];
                            fsm_d.st = ST_RD_BIT;
                        end else begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        fsm_d.oe  = 1'b0;
                        fsm_d.cnt = '0;
                        fsm_d.st  = ST_DATA;
                    end
                end
                ST_RD_BIT: begin
                    if (scl_fall) begin
                        if (fsm_q.cnt == CNT_LAST) begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_RD_ACK;
                        end else begin
                            fsm_d.sh  = {fsm_q.sh[BYTE_W-2:0], 1'b0};
                            fsm_d.cnt = fsm_q.cnt + CNT_ONE;
                            fsm_d.oe  = ~fsm_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        fsm_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.mack) begin
                            fsm_d.sh = rd_data;
                            fsm_d.oe = ~rd_data[BYTE_W-1];
                            fsm_d.st = ST_RD_BIT;
                        end else begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    fsm_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q    <= '0;
            fsm_q.st <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe   = fsm_q.oe;
    assign cmd_vld  = fsm_q.cvld;
    assign data_vld = fsm_q.dvld;
    assign byte_o   = fsm_q.sh;

endmodule

// File: rtl/dpot_wiper_reg.sv
module dpot_wiper_reg
    import dpot_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PRESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic              data_vld,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] wiper_o,
    output logic              shdn_o,
    output logic [BYTE_W-1:0] tap_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] wiper;
        logic              shdn;
    } wreg_t;

    wreg_t wreg_d, wreg_q;

    always_comb begin
        wreg_d = wreg_q;
        if (cmd_vld) begin
            wreg_d.shdn = byte_i[CMD_SHDN_BIT];
            if (byte_i[CMD_MID_BIT]) begin
                wreg_d.wiper = PRESET;
            end
        end
        if (data_vld) begin
            wreg_d.wiper = byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wreg_q.wiper <= PRESET;
            wreg_q.shdn  <= 1'b0;
        end else begin
            wreg_q <= wreg_d;
        end
    end

    assign wiper_o = wreg_q.wiper;
    assign shdn_o  = wreg_q.shdn;
    assign tap_o   = wreg_q.shdn ? '0 : wreg_q.wiper;

endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
    import dpot_pkg::*;
#(
    parameter logic [5:0]        ADDR_HI     = 6'b010110,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] PRESET      = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] wiper_o,
    output logic              shdn_o,
    output logic [BYTE_W-1:0] tap_o
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              cmd_vld;
    logic              data_vld;
    logic [BYTE_W-1:0] bus_byte;

    dpot_sync #(
        .STAGES     (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    dpot_bus_fsm #(
        .ADDR_HI   (ADDR_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .strap_i   (strap_i),
        .rd_data   (wiper_o),
        .sda_oe    (sda_oe_o),
        .cmd_vld   (cmd_vld),
        .data_vld  (data_vld),
        .byte_o    (bus_byte)
    );

    dpot_wiper_reg #(
        .PRESET   (PRESET)
    ) u_wreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_vld  (cmd_vld),
        .data_vld (data_vld),
        .byte_i   (bus_byte),
        .wiper_o  (wiper_o),
        .shdn_o   (shdn_o),
        .tap_o    (tap_o)
    );

endmodule

// File: rtl/dpot_i2c_slave_chk.sv
module dpot_i2c_slave_chk #(
    parameter logic [7:0] PRESET = 8'h80
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] wiper_o,
    input logic       shdn_o,
    input logic [7:0] tap_o,
    input logic       start_evt
);

    // R1
    reset_preset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (wiper_o == PRESET) && !shdn_o && !sda_oe_o);

    // R9
    oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R6
    wiper_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> !scl_i);

    // R5
    shdn_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shdn_o) && (wiper_o != PRESET)) |-> $stable(wiper_o));

    // R7
    shdn_tap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_o && $past(shdn_o)) |-> $stable(tap_o));

    // R7
    shdn_exit_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shdn_o) |-> (tap_o == wiper_o));

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> !sda_oe_o);

endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk #(.PRESET(PRESET)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .wiper_o   (wiper_o),
    .shdn_o    (shdn_o),
    .tap_o     (tap_o),
    .start_evt (start_evt)
);

// File: tb/test_dpot_i2c_slave.sv
module test_dpot_i2c_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 8;

    // {cmd, data, exp_wiper, exp_shdn, exp_tap}
    localparam logic [32:0] VEC [NVEC] = '{
        {8'h00, 8'h3C, 8'h3C, 1'b0, 8'h3C},
        {8'h20, 8'h91, 8'h91, 1'b1, 8'h00},
        {8'h00, 8'hC7, 8'hC7, 1'b0, 8'hC7},
        {8'h40, 8'h5A, 8'h5A, 1'b0, 8'h5A},
        {8'h9F, 8'hFF, 8'hFF, 1'b0, 8'hFF},
        {8'h60, 8'h00, 8'h00, 1'b1, 8'h00},
        {8'h00, 8'h01, 8'h01, 1'b0, 8'h01},
        {8'hA0, 8'h7E, 8'h7E, 1'b1, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] wiper;
    logic       shdn;
    logic [7:0] tap;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpot_i2c_slave i_dpot_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe),
        .wiper_o  (wiper),
        .shdn_o   (shdn),
        .tap_o    (tap)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; wait_q();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic write_txn(input logic [7:0] addr, input logic [7:0] cmd,
                             input logic [7:0] data, input bit with_data, input string req);
        logic ack;
        bus_start();
        send_byte(addr, ack);
        chk({req, " address ACK"}, {7'd0, ack}, 8'd1);
        send_byte(cmd, ack);
        chk({req, " command ACK"}, {7'd0, ack}, 8'd1);
        if (with_data) begin
            send_byte(data, ack);
            chk({req, " data ACK"}, {7'd0, ack}, 8'd1);
        end
        bus_stop();
    endtask

    task automatic read_once(input logic [7:0] addr, output logic [7:0] v);
        logic ack;
        bus_start();
        send_byte(addr, ack);
        chk("R2 read address ACK", {7'd0, ack}, 8'd1);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] rv2;
        logic       ack;

        repeat (5) @(negedge clk);
        // R1: state during and after reset
        chk("R1 wiper in reset", wiper, 8'h80);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 wiper", wiper, 8'h80);
        chk("R1 shutdown", {7'd0, shdn}, 8'd0);
        chk("R1 tap", tap, 8'h80);
        chk("R1 sda released", {7'd0, sda_oe}, 8'd0);

        // Table walk: R4 R5 R6 R7 R8
        for (int k = 0; k < NVEC; k++) begin
            write_txn(8'h58, VEC[k][32:25], VEC[k][24:17], 1'b1, "R6");
            chk("R6 wiper after write", wiper, VEC[k][16:9]);
            chk("R5 shutdown flag", {7'd0, shdn}, {7'd0, VEC[k][8]});
            chk("R7 tap code", tap, VEC[k][7:0]);
            read_once(8'h59, rv);
            chk("R8 readback", rv, VEC[k][16:9]);
            chk("R8 sda released after NACK", {7'd0, sda_oe}, 8'd0);
        end

        // R7: command with shutdown cleared and no data exposes stored code
        write_txn(8'h58, 8'h00, 8'h00, 1'b0, "R7");
        chk("R7 exit shutdown tap", tap, 8'h7E);
        chk("R7 exit shutdown flag", {7'd0, shdn}, 8'd0);

        // R5: readback during shutdown returns stored code
        write_txn(8'h58, 8'h20, 8'h33, 1'b1, "R5");
        chk("R5 tap forced to zero", tap, 8'h00);
        read_once(8'h59, rv);
        chk("R5 stored code kept in shutdown", rv, 8'h33);

        // R4: midscale command alone, also clears shutdown
        write_txn(8'h58, 8'h40, 8'h00, 1'b0, "R4");
        chk("R4 midscale load", wiper, 8'h80);
        chk("R4 tap after midscale", tap, 8'h80);

        // R6: several data bytes in one transaction
        bus_start();
        send_byte(8'h58, ack);
        send_byte(8'h00, ack);
        send_byte(8'h11, ack);
        chk("R6 first data byte", wiper, 8'h11);
        send_byte(8'h22, ack);
        chk("R6 second data byte", wiper, 8'h22);
        send_byte(8'h33, ack);
        chk("R6 third data ACK", {7'd0, ack}, 8'd1);
        bus_stop();
        chk("R6 final code", wiper, 8'h33);

        // R8: repeated read with master ACK, then NACK
        bus_start();
        send_byte(8'h59, ack);
        recv_byte(1'b1, rv);
        recv_byte(1'b0, rv2);
        chk("R8 first read byte", rv, 8'h33);
        chk("R8 repeated read byte", rv2, 8'h33);
        chk("R8 released after NACK", {7'd0, sda_oe}, 8'd0);
        bus_stop();

        // R3: address with wrong strap bit is ignored
        bus_start();
        send_byte(8'h5A, ack);
        chk("R3 no ACK on mismatch", {7'd0, ack}, 8'd0);
        send_byte(8'h20, ack);
        chk("R3 later byte not ACKed", {7'd0, ack}, 8'd0);
        send_byte(8'h44, ack);
        bus_stop();
        chk("R3 wiper untouched", wiper, 8'h33);
        chk("R3 shutdown untouched", {7'd0, shdn}, 8'd0);

        // R3: wrong upper address bits
        bus_start();
        send_byte(8'h78, ack);
        chk("R3 no ACK on wrong upper bits", {7'd0, ack}, 8'd0);
        bus_stop();

        // R2: strap high selects the other address
        strap = 1'b1;
        write_txn(8'h5A, 8'h00, 8'h9C, 1'b1, "R2");
        chk("R2 strap high write", wiper, 8'h9C);
        bus_start();
        send_byte(8'h58, ack);
        chk("R2 old address rejected with strap high", {7'd0, ack}, 8'd0);
        bus_stop();
        strap = 1'b0;

        // R10: repeated START in the middle of a data byte
        bus_start();
        send_byte(8'h58, ack);
        send_byte(8'h00, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte(8'h59, ack);
        chk("R10 repeated START address ACK", {7'd0, ack}, 8'd1);
        recv_byte(1'b0, rv);
        bus_stop();
        chk("R10 no update after aborted byte", rv, 8'h9C);

        // R10: STOP in the middle of a command byte
        bus_start();
        send_byte(8'h58, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk("R10 shutdown unchanged after STOP abort", {7'd0, shdn}, 8'd0);
        chk("R10 wiper unchanged after STOP abort", wiper, 8'h9C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule